// File: doc/BRIEF.md
# Dual-Clock One-Bit Serial FIFO

This block is an elastic store for a single serial bit stream. Bits enter on a free-running write clock and leave on a free-running read clock. The two clocks may be unrelated or may be the same clock. A write is accepted only when the write side reports room. The read side works in first-word-fall-through style: the oldest bit is already on the output whenever the read side reports ready data, and asserting the read enable for one edge consumes it.

The write pointer and the read pointer cross between the clock domains in Gray code. Two status flags help a downstream multiplexer pace itself. One flag reports that the store is at least half occupied. The other reports that the store is close to either end.

The bit waiting on the output is not counted as stored, so the total capacity is one more than the memory depth. Reset is qualified: a low level on the reset input must be seen on four edges of each clock before any state is cleared.

Top module: `sfifo_dual_clk`

## Requirements
- R1: A bit is accepted on a rising wrClk edge only when wrEn and wrReady are both high. Accepted bits leave on rdBit in the order they were written.
- R2: While rdReady is high, rdBit shows the oldest unread bit. That bit is consumed on a rising rdClk edge only when rdEn and rdReady are both high. While rdEn is low, rdReady and rdBit hold.
- R3: After a bit is written into an empty FIFO, rdReady rises and shows that bit on the third rising rdClk edge that follows the write edge. It is still low after the second edge.
- R4: With no reads, exactly DEPTH+1 bits are accepted: DEPTH in memory and one on the output. wrReady is then low, and further writes are dropped. Draining returns exactly those DEPTH+1 bits, in order.
- R5: The stored count is the number of bits in memory, excluding the output bit. halfFull is high when the stored count is at least DEPTH/2 and low when it is below. The flag is updated on wrClk and is valid within four idle cycles.
- R6: nearLimit is high when the stored count is 8 or less, or when it is DEPTH-8 or more. It is low otherwise and settles under the same rule as R5.
- R7: When resetN is sampled low on four wrClk edges and four rdClk edges, the contents are discarded. wrReady, rdReady and halfFull go low and nearLimit goes high. A low pulse that covers only three edges changes neither the contents nor the flags.
- R8: After a qualified reset, wrReady is still low after the first rising wrClk edge with resetN high. It is high after the second such edge.
- R9: With outEn low, rdBit is 0 and rdDrive is 0. With outEn high, rdDrive is 1 and rdBit carries the output bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| resetN | input | 1 | Active-low reset, qualified by edge counts in each domain |
| wrEn | input | 1 | Write enable |
| wrBit | input | 1 | Serial data in |
| wrReady | output | 1 | Room available, write domain |
| rdEn | input | 1 | Read enable |
| rdReady | output | 1 | Output bit valid, read domain |
| outEn | input | 1 | Output enable |
| rdBit | output | 1 | Serial data out, forced to 0 when not enabled |
| rdDrive | output | 1 | High when rdBit is actively driven |
| halfFull | output | 1 | Stored count is at least DEPTH/2 |
| nearLimit | output | 1 | Within 8 of empty or full |

## Verification
The bench counts rdClk edges after a write into an empty store. A design with one synchronizer stage too few or too many shows ready data one cycle off. It fills the store with no reads and counts the accepted bits. A design that forgets the output register as storage, or that lets a write through while wrReady is low, lands on DEPTH or DEPTH+2 instead of DEPTH+1, or returns a corrupted stream. The flags are walked across their exact thresholds: stored counts of 8 and 9, 31 and 32, and 55 and 56. A comparison with the wrong operator, or one that counts the output bit, flips one of those flags. Reset is tested twice: once with a three-edge pulse, which must leave the data untouched, and once with a four-edge pulse, which must empty the store. The bench also checks that wrReady returns on exactly the second edge after release.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;   // write wrBit into memory (write domain)
    logic load;   // move memory head into output register (read domain)
    logic rdClr;  // clear output register (read domain)
  } sfifoStb_t;

endpackage

// File: rtl/sfifo_sync.sv
module sfifo_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int EDGE_GAP  = 8,
  parameter int RST_EDGES = 4,
  parameter int W_SYNC    = 2,
  parameter int R_SYNC    = 2
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     resetN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  output sfifoStb_t                stb,
  output logic [$clog2(DEPTH)-1:0] wAddr,
  output logic [$clog2(DEPTH)-1:0] rAddr,
  output logic                     wrReady,
  output logic                     rdReady,
  output logic                     halfFull,
  output logic                     nearLimit
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(RST_EDGES);
  localparam logic [CW-1:0] CNT_LAST = CW'(RST_EDGES - 1);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LOW_LIM  = PW'(EDGE_GAP);
  localparam logic [PW-1:0] HIGH_LIM = PW'(DEPTH - EDGE_GAP);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [CW-1:0] wRstCnt;
  logic          wClr;
  logic [PW-1:0] wBin, wGray, wBinNext, rGrayW, rBinW, wFill;
  logic          irReg, wWake, hfReg, nlReg, push;

  assign wClr = !resetN && (wRstCnt == CNT_LAST);

  always_ff @(posedge wrClk) begin
    if (resetN)                 wRstCnt <= '0;
    else if (wRstCnt != CNT_LAST) wRstCnt <= wRstCnt + 1'b1;
  end

  sfifo_sync #(.WIDTH(PW), .STAGES(W_SYNC)) rdPtrToWr (
    .clk(wrClk), .clr(wClr), .d(rGray), .q(rGrayW)
  );

  assign push     = wrEn && irReg;
  assign wBinNext = wBin + PW'(push);
  assign rBinW    = fromGray(rGrayW);
  assign wFill    = wBinNext - rBinW;

  always_ff @(posedge wrClk) begin
    if (wClr) begin
      wBin  <= '0;
      wGray <= '0;
      irReg <= 1'b0;
      wWake <= 1'b0;
      hfReg <= 1'b0;
      nlReg <= 1'b1;
    end else begin
      wBin  <= wBinNext;
      wGray <= toGray(wBinNext);
      wWake <= 1'b1;
      irReg <= wWake && (wFill != FULL_CNT);
      hfReg <= (wFill >= HALF_CNT);
      nlReg <= (wFill <= LOW_LIM) || (wFill >= HIGH_LIM);
    end
  end

  // ---------------- read domain ----------------
  logic [CW-1:0] rRstCnt;
  logic          rClr;
  logic [PW-1:0] rBin, rGray, rBinNext, wGrayR, wBinR;
  logic          orReg, memEmpty, take, load;

  assign rClr = !resetN && (rRstCnt == CNT_LAST);

  always_ff @(posedge rdClk) begin
    if (resetN)                 rRstCnt <= '0;
    else if (rRstCnt != CNT_LAST) rRstCnt <= rRstCnt + 1'b1;
  end

  sfifo_sync #(.WIDTH(PW), .STAGES(R_SYNC)) wrPtrToRd (
    .clk(rdClk), .clr(rClr), .d(wGray), .q(wGrayR)
  );

  assign wBinR    = fromGray(wGrayR);
  assign memEmpty = (rBin == wBinR);
  assign take     = rdEn && orReg;
  assign load     = !memEmpty && (!orReg || take);
  assign rBinNext = rBin + PW'(load);

  always_ff @(posedge rdClk) begin
    if (rClr) begin
      rBin  <= '0;
      rGray <= '0;
      orReg <= 1'b0;
    end else begin
      rBin  <= rBinNext;
      rGray <= toGray(rBinNext);
      orReg <= load || (orReg && !take);
    end
  end

  // ---------------- outputs ----------------
  assign stb.push  = push;
  assign stb.load  = load;
  assign stb.rdClr = rClr;
  assign wAddr     = wBin[AW-1:0];
  assign rAddr     = rBin[AW-1:0];
  assign wrReady   = irReg;
  assign rdReady   = orReg;
  assign halfFull  = hfReg;
  assign nearLimit = nlReg;

  // ---------------- assertions ----------------
  p_no_overflow_r4: assert property (@(posedge wrClk) disable iff (!resetN)
    (wBin - rBinW) <= FULL_CNT);

  p_no_underflow_r1: assert property (@(posedge rdClk) disable iff (!resetN)
    (wBinR - rBin) <= FULL_CNT);

  p_ready_wake_r8: assert property (@(posedge wrClk) disable iff (!resetN)
    $rose(irReg) |-> $past(resetN));

  p_head_hold_r2: assert property (@(posedge rdClk) disable iff (!resetN)
    (orReg && !rdEn) |=> orReg);

  p_ready_source_r3: assert property (@(posedge rdClk) disable iff (!resetN)
    $rose(orReg) |-> $past(!memEmpty));

endmodule

// File: rtl/sfifo_dpath.sv
module sfifo_dpath
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  sfifoStb_t                stb,
  input  logic                     wrBit,
  input  logic [$clog2(DEPTH)-1:0] wAddr,
  input  logic [$clog2(DEPTH)-1:0] rAddr,
  output logic                     headBit
);

  logic [DEPTH-1:0] memBits;
  logic             qReg;

  always_ff @(posedge wrClk) begin
    if (stb.push) memBits[wAddr] <= wrBit;
  end

  always_ff @(posedge rdClk) begin
    if (stb.rdClr)     qReg <= 1'b0;
    else if (stb.load) qReg <= memBits[rAddr];
  end

  assign headBit = qReg;

endmodule

// File: rtl/sfifo_dual_clk.sv
module sfifo_dual_clk
  import sfifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int EDGE_GAP  = 8,
  parameter int RST_EDGES = 4
) (
  input  logic wrClk,
  input  logic rdClk,
  input  logic resetN,
  input  logic wrEn,
  input  logic wrBit,
  output logic wrReady,
  input  logic rdEn,
  output logic rdReady,
  input  logic outEn,
  output logic rdBit,
  output logic rdDrive,
  output logic halfFull,
  output logic nearLimit
);

  localparam int AW = $clog2(DEPTH);

  sfifoStb_t       stb;
  logic [AW-1:0]   wAddr, rAddr;
  logic            headBit;

  sfifo_ctrl #(
    .DEPTH(DEPTH), .EDGE_GAP(EDGE_GAP), .RST_EDGES(RST_EDGES),
    .W_SYNC(2), .R_SYNC(2)
  ) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .resetN(resetN),
    .wrEn(wrEn), .rdEn(rdEn), .stb(stb),
    .wAddr(wAddr), .rAddr(rAddr),
    .wrReady(wrReady), .rdReady(rdReady),
    .halfFull(halfFull), .nearLimit(nearLimit)
  );

  sfifo_dpath #(.DEPTH(DEPTH)) dpath_i (
    .wrClk(wrClk), .rdClk(rdClk), .stb(stb), .wrBit(wrBit),
    .wAddr(wAddr), .rAddr(rAddr), .headBit(headBit)
  );

  assign rdBit   = outEn & headBit;
  assign rdDrive = outEn;

endmodule

// File: tb/sfifo_dual_clk_tb_top.sv
module sfifo_dual_clk_tb_top;

  localparam int DEPTH = 64;
  localparam int GAP   = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic resetN = 1'b0;
  logic wrEn = 1'b0, wrBit = 1'b0, rdEn = 1'b0, outEn = 1'b1;
  logic wrReady, rdReady, rdBit, rdDrive, halfFull, nearLimit;

  sfifo_dual_clk #(.DEPTH(DEPTH), .EDGE_GAP(GAP), .RST_EDGES(4)) dut_i (
    .wrClk(clk), .rdClk(clk), .resetN(resetN),
    .wrEn(wrEn), .wrBit(wrBit), .wrReady(wrReady),
    .rdEn(rdEn), .rdReady(rdReady), .outEn(outEn),
    .rdBit(rdBit), .rdDrive(rdDrive),
    .halfFull(halfFull), .nearLimit(nearLimit)
  );

  // {length[4:0], pattern[15:0]}; bit i of pattern is written i-th
  localparam logic [20:0] VEC [8] = '{
    {5'd1,  16'h0001}, {5'd3,  16'h0005}, {5'd9,  16'h01A5}, {5'd10, 16'h02C3},
    {5'd16, 16'hBEEF}, {5'd2,  16'h0002}, {5'd12, 16'h0F0F}, {5'd7,  16'h0055}
  };

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic logic patBit(input int k);
    return k[1] ^ k[4];
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeN(input int n);
    for (int i = 0; i < n; i++) begin
      wrBit = patBit(i);
      wrEn  = 1'b1;
      @(negedge clk);
    end
    wrEn = 1'b0;
  endtask

  task automatic readN(input int n);
    rdEn = 1'b1;
    repeat (n) @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic flagCheck(input string tag, input int stored);
    chk({tag, " R5 halfFull"}, halfFull, stored >= DEPTH / 2);
    chk({tag, " R6 nearLimit"}, nearLimit, (stored <= GAP) || (stored >= DEPTH - GAP));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    // ---- reset state and wake-up (R7, R8) ----
    settle(6);
    chk("R7 reset wrReady", wrReady, 0);
    chk("R7 reset rdReady", rdReady, 0);
    chk("R7 reset halfFull", halfFull, 0);
    chk("R7 reset nearLimit", nearLimit, 1);
    resetN = 1'b1;
    @(negedge clk);
    chk("R8 wrReady after first edge", wrReady, 0);
    @(negedge clk);
    chk("R8 wrReady after second edge", wrReady, 1);

    // ---- vector table: order and flags (R1, R2, R6) ----
    for (int v = 0; v < 8; v++) begin
      int len;
      logic [15:0] pat;
      len = int'(VEC[v][20:16]);
      pat = VEC[v][15:0];
      chk("R1 ready before burst", wrReady, 1);
      for (int i = 0; i < len; i++) begin
        wrBit = pat[i];
        wrEn  = 1'b1;
        @(negedge clk);
      end
      wrEn = 1'b0;
      settle(6);
      flagCheck("vector", len - 1);
      for (int i = 0; i < len; i++) begin
        chk("R2 ready during readout", rdReady, 1);
        chk("R1 bit order", rdBit, pat[i]);
        rdEn = 1'b1;
        @(negedge clk);
      end
      rdEn = 1'b0;
      chk("R2 empty after readout", rdReady, 0);
      settle(4);
    end

    // ---- first-bit latency (R3) ----
    wrBit = 1'b1;
    wrEn  = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    chk("R3 not ready after edge 1", rdReady, 0);
    @(negedge clk);
    chk("R3 not ready after edge 2", rdReady, 0);
    @(negedge clk);
    chk("R3 ready after edge 3", rdReady, 1);
    chk("R3 first bit shown", rdBit, 1);

    // ---- output enable and hold (R9, R2) ----
    outEn = 1'b0;
    #1;
    chk("R9 bit forced low", rdBit, 0);
    chk("R9 drive low", rdDrive, 0);
    outEn = 1'b1;
    #1;
    chk("R9 bit driven", rdBit, 1);
    chk("R9 drive high", rdDrive, 1);
    settle(3);
    chk("R2 hold ready without rdEn", rdReady, 1);
    chk("R2 hold bit without rdEn", rdBit, 1);
    readN(1);
    chk("R2 consumed", rdReady, 0);
    settle(4);

    // ---- fill to capacity with overflow attempts (R4, R5, R6) ----
    begin
      int accepted;
      int got;
      int bad;
      accepted = 0;
      wrEn = 1'b1;
      for (int i = 0; i < 120; i++) begin
        wrBit = patBit(accepted);
        if (wrReady) accepted++;
        @(negedge clk);
      end
      wrEn = 1'b0;
      chk("R4 accepted count", accepted, DEPTH + 1);
      chk("R4 wrReady low when full", wrReady, 0);
      settle(6);
      flagCheck("full", DEPTH);
      got = 0;
      bad = 0;
      rdEn = 1'b1;
      for (int i = 0; i < 150; i++) begin
        if (rdReady) begin
          if (rdBit !== patBit(got)) bad++;
          got++;
        end
        @(negedge clk);
      end
      rdEn = 1'b0;
      chk("R4 drained count", got, DEPTH + 1);
      chk("R4 drained data mismatches", bad, 0);
    end
    settle(6);

    // ---- short reset pulse is ignored (R7) ----
    writeN(5);
    settle(6);
    resetN = 1'b0;
    settle(3);
    resetN = 1'b1;
    settle(4);
    chk("R7 short pulse keeps rdReady", rdReady, 1);
    chk("R7 short pulse keeps wrReady", wrReady, 1);
    flagCheck("short pulse", 4);
    for (int i = 0; i < 5; i++) begin
      chk("R7 short pulse keeps data", rdBit, patBit(i));
      rdEn = 1'b1;
      @(negedge clk);
    end
    rdEn = 1'b0;
    chk("R7 short pulse drained", rdReady, 0);
    settle(4);

    // ---- qualified reset with data (R7, R8) ----
    writeN(40);
    settle(6);
    chk("R5 halfFull before reset", halfFull, 1);
    resetN = 1'b0;
    settle(4);
    chk("R7 qualified halfFull", halfFull, 0);
    chk("R7 qualified nearLimit", nearLimit, 1);
    chk("R7 qualified wrReady", wrReady, 0);
    chk("R7 qualified rdReady", rdReady, 0);
    resetN = 1'b1;
    @(negedge clk);
    chk("R8 wrReady after first edge again", wrReady, 0);
    @(negedge clk);
    chk("R8 wrReady after second edge again", wrReady, 1);
    settle(4);
    chk("R7 contents discarded", rdReady, 0);

    // ---- flag thresholds (R5, R6) ----
    writeN(10);
    settle(6);
    flagCheck("stored 9", 9);
    readN(1);
    settle(6);
    flagCheck("stored 8", 8);
    writeN(24);
    settle(6);
    flagCheck("stored 32", 32);
    readN(1);
    settle(6);
    flagCheck("stored 31", 31);
    writeN(24);
    settle(6);
    flagCheck("stored 55", 55);
    writeN(1);
    settle(6);
    flagCheck("stored 56", 56);

    report();
    $finish;
  end

endmodule